// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block runs a DMA transfer list kept in memory. Each list entry is a 64-bit descriptor. It gives a data address, a byte count and a few attribute flags. Software writes the list, then presents its base address together with a one-cycle start pulse. The engine reads the entries one at a time, in address order. For each entry that asks for data movement, it hands the address and byte count to a downstream transfer agent and waits for that agent to acknowledge completion.

The walk ends in one of two ways. Normally it ends after the entry that carries the end flag, and a one-cycle done pulse follows. A malformed entry instead ends the walk in an error state. That state is held, together with the memory address of the offending entry, until software starts a new walk. Only one descriptor read or one transfer request is outstanding at any time.

Top module: `sg_desc_walker`

## Requirements
- R1: A start pulse accepted by the engine loads the entry pointer from `table_base` with its two low bits forced to zero. The first descriptor read is issued at that aligned address.
- R2: A descriptor word is laid out as follows. Bits [63:32] hold the data address. Bits [31:16] hold the length. Bit 0 is the valid flag and bit 1 is the end flag. Bits [5:4] hold the action: 2'b10 means move data, 2'b00 means skip, and 2'b01 and 2'b11 are unsupported. `rd_en` stays high with a stable `rd_addr` until `rd_valid` returns the word on `rd_data`.
- R3: For a move-data entry, `xfer_req` stays high with stable `xfer_addr` and `xfer_len` until `xfer_done`. A length field of zero is issued as 65536 (17'h10000).
- R4: Entries are processed strictly in order. The pointer grows by 8 bytes per entry, so each entry yields its transfer in list order.
- R5: After the end-flagged entry completes, `done` is high for exactly one cycle and the engine returns to idle.
- R6: A skip entry issues no transfer and the walk moves to the next entry. A skip entry carrying the end flag finishes the walk with `done`.
- R7: An entry with the valid flag clear issues no transfer. It raises `error`, and `err_addr` holds the address that entry was read from.
- R8: An entry with an unsupported action issues no transfer. It raises `error` with its address in `err_addr`.
- R9: `error` and `err_addr` hold their values until a new start is accepted. The accepted start clears `error` on the following cycle.
- R10: A start arriving while a walk is in progress (fetching, decoding, transferring or advancing) is ignored, and the running walk completes unchanged.
- R11: A start presented in the cycle `done` is high is accepted and begins a new walk at once.
- R12: After reset, `rd_en`, `xfer_req`, `done` and `error` are low.
- R13: `rd_en` and `xfer_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a walk |
| table_base | input | 32 | Byte address of the first descriptor |
| rd_en | output | 1 | Descriptor read request, held until answered |
| rd_addr | output | 32 | Address of the descriptor being read |
| rd_valid | input | 1 | Read data present this cycle |
| rd_data | input | 64 | Descriptor word |
| xfer_req | output | 1 | Data transfer request, held until done |
| xfer_addr | output | 32 | Transfer start address |
| xfer_len | output | 17 | Transfer byte count (1 to 65536) |
| xfer_done | input | 1 | Transfer agent finished the current request |
| done | output | 1 | One-cycle pulse at the end of a clean walk |
| error | output | 1 | Walk stopped on a bad entry; held until restart |
| err_addr | output | 32 | Memory address of the bad entry |

## Verification
Two events can coincide. A software start can land in the very cycle the completion pulse is shown. A restart can also be requested while the last transfer's acknowledge is still pending. The bench watches `done` on the falling edge and raises `start` at once, so the two meet at the next rising edge. The result is judged from two completion pulses and from both walks' transfers in the log. A second test drives a start while a transfer is outstanding and confirms that the log matches only the first list.

// File: rtl/sg_walk_pkg.sv
// Package: shared widths, descriptor field positions, FSM state and action codes.
// Assumes the 64-bit descriptor layout given in the brief (R2).
package sg_walk_pkg;
    localparam int ADDR_W   = 32;
    localparam int LEN_W    = 16;
    localparam int BYTES_W  = LEN_W + 1;
    localparam int DESC_W   = 64;
    localparam int ATTR_VALID_BIT = 0;
    localparam int ATTR_END_BIT   = 1;
    localparam int ATTR_ACT_LO    = 4;
    localparam int LEN_LO         = 16;
    localparam int DADDR_LO       = 32;

    typedef enum logic [1:0] {
        ACT_SKIP = 2'b00,
        ACT_RSV  = 2'b01,
        ACT_MOVE = 2'b10,
        ACT_LNK  = 2'b11
    } act_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_XFER,
        ST_ADVANCE,
        ST_DONE,
        ST_ERROR
    } walk_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [BYTES_W-1:0] bytes;
        logic               valid;
        logic               last;
        act_t               act;
    } desc_t;
endpackage

// File: rtl/sg_desc_decode.sv
// Module: sg_desc_decode
// Splits a raw 64-bit descriptor word into its fields. A zero length is
// widened to 65536 bytes. Purely combinational; assumes the bit layout
// of R2. Attribute bits other than valid, end and action are ignored.
module sg_desc_decode
    import sg_walk_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    output desc_t             fields
);
    logic [LEN_W-1:0] len_field;

    // Field extraction and zero-length widening.
    always_comb begin
        len_field     = raw[LEN_LO +: LEN_W];
        fields.addr   = raw[DADDR_LO +: ADDR_W];
        fields.bytes  = (len_field == '0) ? BYTES_W'(1 << LEN_W)
                                          : {1'b0, len_field};
        fields.valid  = raw[ATTR_VALID_BIT];
        fields.last   = raw[ATTR_END_BIT];
        fields.act    = act_t'(raw[ATTR_ACT_LO +: 2]);
    end
endmodule

// File: rtl/sg_ptr_unit.sv
// Module: sg_ptr_unit
// Holds the address of the current descriptor. A load takes the table
// base with the low ALIGN_BITS cleared; an advance steps by STEP bytes.
// Assumes load and advance are never requested together.
module sg_ptr_unit #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2,
    parameter int STEP       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] base_aligned;

    // Clear alignment bits of the supplied base.
    always_comb begin
        base_aligned = {load_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end

    // Pointer register: reset, load aligned base, or step to next entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= base_aligned;
        end else if (advance) begin
            ptr <= ptr + STEP_V;
        end
    end

    assert_step_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (ptr - $past(ptr)) == STEP_V);
endmodule

// File: rtl/sg_walk_fsm.sv
// Module: sg_walk_fsm
// Sequencer: idle, fetch, decode, transfer, advance, then done or error.
// Holds the latched descriptor and the failing address. Assumes the read
// port answers each request exactly once and the transfer agent acknowledges
// each request exactly once.
module sg_walk_fsm
    import sg_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_valid,
    input  desc_t             desc_in,
    input  logic              xfer_done,
    input  logic [ADDR_W-1:0] ptr,
    output logic              load,
    output logic              advance,
    output logic              fetch_active,
    output logic              xfer_active,
    output logic              done_pulse,
    output logic              err_active,
    output logic [ADDR_W-1:0] err_addr,
    output desc_t             desc_q
);
    walk_state_t state_q, state_d;
    logic        accept;
    logic        busy;
    logic        bad_entry;

    // Start is honoured only when no walk is running.
    always_comb begin
        accept = start && (state_q == ST_IDLE || state_q == ST_DONE ||
                           state_q == ST_ERROR);
        busy   = (state_q == ST_FETCH) || (state_q == ST_DECODE) ||
                 (state_q == ST_XFER)  || (state_q == ST_ADVANCE);
        bad_entry = !desc_q.valid ||
                    (desc_q.act != ACT_MOVE && desc_q.act != ACT_SKIP);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (accept) state_d = ST_FETCH;
            ST_FETCH:   if (rd_valid) state_d = ST_DECODE;
            ST_DECODE: begin
                if (bad_entry)                 state_d = ST_ERROR;
                else if (desc_q.act == ACT_MOVE) state_d = ST_XFER;
                else if (desc_q.last)          state_d = ST_DONE;
                else                           state_d = ST_ADVANCE;
            end
            ST_XFER:    if (xfer_done) state_d = desc_q.last ? ST_DONE : ST_ADVANCE;
            ST_ADVANCE: state_d = ST_FETCH;
            ST_DONE:    state_d = accept ? ST_FETCH : ST_IDLE;
            ST_ERROR:   if (accept) state_d = ST_FETCH;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Descriptor latch on read return.
    always_ff @(posedge clk) begin
        if (!rst_n)                              desc_q <= '0;
        else if (state_q == ST_FETCH && rd_valid) desc_q <= desc_in;
    end

    // Capture the address of a rejected entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  err_addr <= '0;
        else if (state_q == ST_DECODE && bad_entry)  err_addr <= ptr;
    end

    // State-decoded controls.
    always_comb begin
        load         = accept;
        advance      = (state_q == ST_ADVANCE);
        fetch_active = (state_q == ST_FETCH);
        xfer_active  = (state_q == ST_XFER);
        done_pulse   = (state_q == ST_DONE);
        err_active   = (state_q == ST_ERROR);
    end

    assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_active && !rd_valid) |=> (fetch_active && $stable(ptr)));
    assert_xfer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !xfer_done) |=> (xfer_active && $stable(desc_q)));
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_active && !start) |=> (err_active && $stable(err_addr)));
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_active && start) |=> !err_active);
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !advance) |=> $stable(ptr));
endmodule

// File: rtl/sg_desc_walker.sv
// Module: sg_desc_walker (top)
// Walks a list of 64-bit scatter-gather descriptors starting at table_base,
// issuing one transfer per move-data entry until the end-flagged entry or a
// bad entry. Assumes a single-outstanding read port and transfer agent.
module sg_desc_walker
    import sg_walk_pkg::*;
#(
    parameter int ENTRY_BYTES = 8,
    parameter int ALIGN_BITS  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  table_base,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_valid,
    input  logic [DESC_W-1:0]  rd_data,
    output logic               xfer_req,
    output logic [ADDR_W-1:0]  xfer_addr,
    output logic [BYTES_W-1:0] xfer_len,
    input  logic               xfer_done,
    output logic               done,
    output logic               error,
    output logic [ADDR_W-1:0]  err_addr
);
    logic              load;
    logic              advance;
    logic [ADDR_W-1:0] ptr;
    desc_t             desc_word;
    desc_t             desc_held;

    sg_desc_decode u_decode (
        .raw    (rd_data),
        .fields (desc_word)
    );

    sg_ptr_unit #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS),
        .STEP       (ENTRY_BYTES)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (table_base),
        .advance   (advance),
        .ptr       (ptr)
    );

    sg_walk_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .rd_valid     (rd_valid),
        .desc_in      (desc_word),
        .xfer_done    (xfer_done),
        .ptr          (ptr),
        .load         (load),
        .advance      (advance),
        .fetch_active (rd_en),
        .xfer_active  (xfer_req),
        .done_pulse   (done),
        .err_active   (error),
        .err_addr     (err_addr),
        .desc_q       (desc_held)
    );

    // Transfer request fields come from the latched descriptor.
    always_comb begin
        rd_addr   = ptr;
        xfer_addr = desc_held.addr;
        xfer_len  = desc_held.bytes;
    end

    assert_ports_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && xfer_req));
    assert_read_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr[ALIGN_BITS-1:0] == '0));
endmodule

// File: tb/test_sg_desc_walker.sv
`timescale 1ns/1ps
module test_sg_desc_walker;
    typedef struct packed {
        logic [11:0] base;
        logic [7:0]  n;
        logic [1:0]  kind;   // 0 clean, 1 invalid, 2 unsupported action, 3 skip
        logic [7:0]  sidx;
        logic [15:0] seed;
        logic [3:0]  dly;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{12'h100, 8'd1, 2'd0, 8'd0, 16'h0200, 4'd0},
        '{12'h200, 8'd4, 2'd0, 8'd0, 16'h1000, 4'd2},
        '{12'h300, 8'd3, 2'd0, 8'd0, 16'h0000, 4'd1},
        '{12'h403, 8'd2, 2'd0, 8'd0, 16'h0123, 4'd0},
        '{12'h500, 8'd4, 2'd1, 8'd2, 16'h0040, 4'd0},
        '{12'h600, 8'd3, 2'd2, 8'd1, 16'h0080, 4'd1},
        '{12'h700, 8'd3, 2'd2, 8'd0, 16'h0100, 4'd0},
        '{12'h800, 8'd3, 2'd3, 8'd1, 16'h0300, 4'd3},
        '{12'h900, 8'd2, 2'd3, 8'd1, 16'h0010, 4'd0},
        '{12'hA00, 8'd5, 2'd0, 8'd0, 16'hFFFF, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] table_base = '0;
    logic        rd_en, rd_valid;
    logic [31:0] rd_addr;
    logic [63:0] rd_data;
    logic        xfer_req, xfer_done;
    logic [31:0] xfer_addr, err_addr;
    logic [16:0] xfer_len;
    logic        done, error;

    always #2.5 clk = ~clk;

    sg_desc_walker i_sg_desc_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_done(xfer_done), .done(done), .error(error), .err_addr(err_addr)
    );

    logic [63:0] mem [0:511];
    logic [3:0]  xfer_dly = '0;
    logic [3:0]  wcnt;

    // Memory model: one-cycle read latency, one answer per request.
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en && !rd_valid;
            rd_data  <= mem[rd_addr[11:3]];
        end
    end

    // Transfer agent: acknowledges after xfer_dly wait cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            xfer_done <= 1'b0;
            wcnt      <= '0;
        end else if (xfer_req && !xfer_done) begin
            if (wcnt >= xfer_dly) begin
                xfer_done <= 1'b1;
                wcnt      <= '0;
            end else begin
                wcnt <= wcnt + 4'd1;
            end
        end else begin
            xfer_done <= 1'b0;
        end
    end

    // Monitor, sampled on falling edges.
    logic        log_clr = 1'b0;
    int          nlog, done_cnt, done_wide, excl_bad;
    logic        err_seen, prev_err, prev_done, first_ok;
    logic [31:0] first_rd;
    logic [31:0] log_addr [0:15];
    logic [16:0] log_len  [0:15];

    always @(negedge clk) begin
        prev_err  <= error;
        prev_done <= done;
        if (log_clr) begin
            nlog <= 0; done_cnt <= 0; done_wide <= 0; excl_bad <= 0;
            err_seen <= 1'b0; first_ok <= 1'b0; first_rd <= '0;
        end else begin
            if (done) done_cnt <= done_cnt + 1;
            if (done && prev_done) done_wide <= done_wide + 1;
            if (error && !prev_err) err_seen <= 1'b1;
            if (rd_en && !first_ok) begin
                first_ok <= 1'b1;
                first_rd <= rd_addr;
            end
            if (xfer_req && xfer_done && nlog < 16) begin
                log_addr[nlog] <= xfer_addr;
                log_len[nlog]  <= xfer_len;
                nlog <= nlog + 1;
            end
            if (rd_en && xfer_req) excl_bad <= excl_bad + 1;
        end
    end

    int nchk = 0;
    int nfail = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    int cycles = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    // Expected results, built from the requirements.
    int          exp_n;
    bit          exp_err, exp_done;
    logic [31:0] exp_err_addr;
    logic [31:0] exp_addr [0:15];
    logic [16:0] exp_len  [0:15];

    function automatic logic [31:0] daddr(input vec_t v, input int i);
        return 32'h4000_0000 + ({20'h0, v.base} << 12) + 32'(i) * 32'h1_0000;
    endfunction

    function automatic logic [15:0] dlen(input vec_t v, input int i);
        return 16'(v.seed * (i + 1));
    endfunction

    task automatic build(input vec_t v);
        logic [31:0] ab;
        ab = {20'h0, v.base} & ~32'h3;
        exp_n = 0; exp_err = 0; exp_done = 0; exp_err_addr = '0;
        for (int i = 0; i < int'(v.n); i++) begin
            logic [15:0] attr;
            logic [15:0] ln;
            attr = 16'h0001 | (16'h2 << 4);            // valid, move data
            if (i == int'(v.n) - 1) attr = attr | 16'h0002;
            if (i == int'(v.sidx)) begin
                if (v.kind == 2'd1) attr = attr & ~16'h0001;
                if (v.kind == 2'd2) attr = (attr & ~16'h0030) | ((v.sidx[0] ? 16'h1 : 16'h3) << 4);
                if (v.kind == 2'd3) attr = attr & ~16'h0030;
            end
            ln = dlen(v, i);
            mem[(ab + 32'(i) * 8) >> 3] = {daddr(v, i), ln, attr};
        end
        for (int i = 0; i < int'(v.n); i++) begin
            logic [15:0] ln;
            ln = dlen(v, i);
            if ((v.kind == 2'd1 || v.kind == 2'd2) && i == int'(v.sidx)) begin
                exp_err = 1;
                exp_err_addr = ab + 32'(i) * 8;
                break;
            end
            if (!(v.kind == 2'd3 && i == int'(v.sidx))) begin
                exp_addr[exp_n] = daddr(v, i);
                exp_len[exp_n]  = (ln == 16'h0) ? 17'h10000 : {1'b0, ln};
                exp_n++;
            end
            if (i == int'(v.n) - 1) exp_done = 1;
        end
    endtask

    task automatic clear_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk);
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic pulse_start(input logic [31:0] b);
        @(negedge clk);
        table_base = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (done_cnt > 0 || err_seen) break;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic compare(input vec_t v, input string otag);
        check(first_rd == ({20'h0, v.base} & ~32'h3), "R1", first_rd,
              {20'h0, v.base} & ~32'h3);
        check(nlog == exp_n, "R4", nlog, exp_n);
        for (int j = 0; j < exp_n && j < nlog; j++) begin
            check(log_addr[j] == exp_addr[j], "R2", log_addr[j], exp_addr[j]);
            check(log_len[j] == exp_len[j], "R3", log_len[j], exp_len[j]);
        end
        check(done_cnt == (exp_done ? 1 : 0), otag, done_cnt, exp_done);
        check(error == exp_err, otag, error, exp_err);
        if (exp_err) check(err_addr == exp_err_addr, otag, err_addr, exp_err_addr);
        check(done_wide == 0, "R5", done_wide, 0);
        check(excl_bad == 0, "R13", excl_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        // R12: reset state.
        repeat (4) @(negedge clk);
        check(!rd_en && !xfer_req && !done && !error, "R12",
              {rd_en, xfer_req, done, error}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!rd_en && !xfer_req && !done && !error, "R12",
              {rd_en, xfer_req, done, error}, 0);

        // Vector table walk.
        for (int vi = 0; vi < NV; vi++) begin
            vec_t  v;
            string otag;
            bit    was_err;
            v = VECS[vi];
            otag = (v.kind == 2'd1) ? "R7" : (v.kind == 2'd2) ? "R8" :
                   (v.kind == 2'd3) ? "R6" : "R5";
            build(v);
            xfer_dly = v.dly;
            was_err = error;
            clear_log();
            pulse_start({20'h0, v.base});
            if (was_err) check(!error, "R9", error, 0);
            wait_end();
            compare(v, otag);
        end

        // R9: error held with its address while no start arrives.
        begin
            vec_t v;
            logic [31:0] ea;
            v = VECS[4];
            build(v);
            clear_log();
            pulse_start({20'h0, v.base});
            wait_end();
            ea = err_addr;
            repeat (20) @(negedge clk);
            check(error == 1'b1, "R9", error, 1);
            check(err_addr == ea, "R9", err_addr, ea);
        end

        // R10: start during a running walk is ignored.
        begin
            vec_t v;
            v = VECS[1];
            build(v);
            xfer_dly = 4'd5;
            clear_log();
            pulse_start({20'h0, v.base});
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (xfer_req) break;
            end
            table_base = 32'h100; start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (3) @(negedge clk);
            table_base = 32'h300; start = 1'b1;    // also while fetching/advancing
            repeat (4) @(negedge clk);
            start = 1'b0;
            wait_end();
            compare(v, "R10");
        end

        // R11: start in the same cycle as done begins a new walk.
        begin
            vec_t v;
            v = VECS[0];
            build(v);
            xfer_dly = 4'd0;
            clear_log();
            pulse_start({20'h0, v.base});
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (done) break;
            end
            table_base = {20'h0, v.base}; start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (40) @(negedge clk);
            check(done_cnt == 2, "R11", done_cnt, 2);
            check(nlog == 2, "R11", nlog, 2);
            check(log_addr[1] == exp_addr[0], "R11", log_addr[1], exp_addr[0]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule